// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Early Warning

The block is a watchdog timer that sits on a simple 32-bit register bus. It is paced by a slow timebase that nominally delivers 32768 ticks per second, seen here as a single-cycle `tick` enable in the bus clock domain. Software programs a 32-bit timeout and a 32-bit early-warning threshold, each written as two 16-bit halves. A small load sequencer hands the staged values to the down-counter after a settling delay of two timebase ticks. While that delay runs, a busy flag is visible in the status word. When counting is enabled, the counter steps down by one per tick. When it steps onto the early threshold, it latches a warning flag that can drive an interrupt. When it reaches zero, it latches an expiry flag that can drive a reset request.

Every register except the key register is protected. A write to a protected register does nothing until the key value 0xE551 is written to the key register. Writing zero to the key register restores the protection, and the block leaves reset protected. The warning and expiry flags are sticky. They are cleared by writing ones to the acknowledge register, and a new event in the same cycle wins over a clear. The whole-seconds figure is the count divided by 32768, which software works out itself from the two count halves.

The load sequencer is a three-state machine:
- **LD_IDLE**: not busy. Any accepted write to one of the four load-value registers moves it to LD_SETTLE and clears the tick tally.
- **LD_SETTLE**: busy. Each tick adds one to the tally. The tick that completes the second step moves it to LD_COMMIT. A further load write returns it to the start of LD_SETTLE.
- **LD_COMMIT**: busy for one clock, during which the counter takes the staged values. It then returns to LD_IDLE. A load write seen in this cycle moves it to LD_SETTLE again.

Top module: `wdtk_watchdog`

## Requirements
- R1: After reset the key register (offset 0x20) reads 1 (protected). Writing 0xE551 to it makes it read 0. Writing 0x00000000 to it makes it read 1 again.
- R2: While protected, writes to every other register have no effect. The control value is unchanged, the acknowledge register clears no flag, and a load-value write does not raise busy.
- R3: The timeout is written at 0x00 (bits 15:0) and 0x04 (bits 31:16). The early threshold is written at 0x2C (low half) and 0x30 (high half). Only bits 15:0 of each write are kept and read back. The count reads back as a low half at 0x18 and a high half at 0x1C.
- R4: Control (0x08) bit 0 enables the interrupt, bit 1 enables counting, bit 2 is a stored mode bit, and bit 3 enables the reset request. All four bits read back as written.
- R5: Status (0x10) bit 4 (busy) is 1 from the clock after a load write. It stays 1 through two timebase ticks and one further clock. It drops in the same clock in which the count takes the new timeout.
- R6: With counting enabled, each tick lowers the count by one. With counting disabled the count is frozen. The count holds at zero.
- R7: Status bit 0 (warning) sets on the tick that moves the count onto the early threshold. `irq_o` is warning AND control bit 0 AND NOT mask (0x14) bit 0.
- R8: Status bit 3 (expiry) sets on the tick that moves the count from 1 to 0. `rst_req_o` is expiry AND control bit 3.
- R9: Writing 1 to bit 0 or bit 3 of the acknowledge register (0x0C) clears warning or expiry respectively. A set event in the same clock takes priority over the clear.
- R10: A load while counting is running restarts the countdown from the new timeout once busy drops. Until then the old count keeps stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase step enable, one clock wide |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | Expiry reset request |

## Verification
The acknowledge write and the set event of the same flag can land in one clock. The bench provokes this by driving the tick that makes the count hit the early threshold, or hit zero, together with an acknowledge write of the matching bit. The flag must then read 1 afterwards, because the set wins. A plain acknowledge in a later clock must still empty both flags. The sweep over every small timeout and threshold pair checks the exact tick on which each flag appears, and the reload case checks that old-count stepping and the commit meet in the correct clock.

// File: rtl/wdtk_pkg.sv
package wdtk_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_TMO_LO   = 6'h00;
    localparam logic [ADDR_W-1:0] A_TMO_HI   = 6'h04;
    localparam logic [ADDR_W-1:0] A_CFG      = 6'h08;
    localparam logic [ADDR_W-1:0] A_ACK      = 6'h0C;
    localparam logic [ADDR_W-1:0] A_STAT     = 6'h10;
    localparam logic [ADDR_W-1:0] A_HIDE     = 6'h14;
    localparam logic [ADDR_W-1:0] A_CUR_LO   = 6'h18;
    localparam logic [ADDR_W-1:0] A_CUR_HI   = 6'h1C;
    localparam logic [ADDR_W-1:0] A_KEY      = 6'h20;
    localparam logic [ADDR_W-1:0] A_EARLY_LO = 6'h2C;
    localparam logic [ADDR_W-1:0] A_EARLY_HI = 6'h30;

    localparam int unsigned CFG_IRQ_EN = 0;
    localparam int unsigned CFG_RUN    = 1;
    localparam int unsigned CFG_MODE   = 2;
    localparam int unsigned CFG_RST_EN = 3;
    localparam int unsigned CFG_W      = 4;

    localparam int unsigned ST_WARN = 0;
    localparam int unsigned ST_EXP  = 3;
    localparam int unsigned ST_BUSY = 4;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_SETTLE,
        LD_COMMIT
    } ld_state_t;
endpackage

// File: rtl/wdtk_loadseq.sv
module wdtk_loadseq
    import wdtk_pkg::*;
#(
    parameter int unsigned SETTLE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_wr,
    input  logic tick,
    output logic busy,
    output logic commit
);
    localparam int unsigned TW = $clog2(SETTLE_TICKS + 1);

    ld_state_t       state_q, state_d;
    logic [TW-1:0]   tally_q, tally_d;

    always_comb begin
        state_d = state_q;
        tally_d = tally_q;
        unique case (state_q)
            LD_IDLE: begin
                if (load_wr) begin
                    state_d = LD_SETTLE;
                    tally_d = '0;
                end
            end
            LD_SETTLE: begin
                if (load_wr) begin
                    tally_d = '0;
                end else if (tick) begin
                    if (tally_q == TW'(SETTLE_TICKS - 1)) begin
                        state_d = LD_COMMIT;
                    end else begin
                        tally_d = tally_q + 1'b1;
                    end
                end
            end
            LD_COMMIT: begin
                tally_d = '0;
                state_d = load_wr ? LD_SETTLE : LD_IDLE;
            end
            default: state_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            tally_q <= '0;
        end else begin
            state_q <= state_d;
            tally_q <= tally_d;
        end
    end

    always_comb begin
        busy   = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            LD_IDLE:   busy = 1'b0;
            LD_SETTLE: busy = 1'b1;
            LD_COMMIT: begin
                busy   = 1'b1;
                commit = 1'b1;
            end
            default:   busy = 1'b0;
        endcase
    end

    AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> busy); // R5
    AST_COMMIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(commit) |-> $past(tick)); // R5
endmodule

// File: rtl/wdtk_count.sv
module wdtk_count #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             commit,
    input  logic [CNT_W-1:0] tmo_val,
    input  logic [CNT_W-1:0] early_val,
    input  logic             clr_warn,
    input  logic             clr_exp,
    output logic [CNT_W-1:0] count,
    output logic             warn,
    output logic             expired
);
    logic [CNT_W-1:0] thresh_q;
    logic             step;
    logic [CNT_W-1:0] next_cnt;
    logic             warn_hit, exp_hit;

    always_comb begin
        step     = !commit && run && tick && (count != '0);
        next_cnt = count - 1'b1;
        warn_hit = step && (next_cnt == thresh_q);
        exp_hit  = step && (next_cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            thresh_q <= '0;
            warn     <= 1'b0;
            expired  <= 1'b0;
        end else begin
            if (commit) begin
                count    <= tmo_val;
                thresh_q <= early_val;
            end else if (step) begin
                count <= next_cnt;
            end
            warn    <= warn_hit || (warn && !clr_warn);
            expired <= exp_hit || (expired && !clr_exp);
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && run && tick && count != '0) |=> (count == $past(count) - 1'b1)); // R6
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !run) |=> $stable(count)); // R6
    AST_EXP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr_exp) |=> expired); // R9
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (count == $past(tmo_val))); // R10
endmodule

// File: rtl/wdtk_regs.sv
module wdtk_regs
    import wdtk_pkg::*;
#(
    parameter int unsigned    HALF_W = 16,
    parameter logic [15:0]    UNLOCK = 16'hE551
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic                busy,
    input  logic [2*HALF_W-1:0] count,
    input  logic                warn,
    input  logic                expired,
    output logic [CFG_W-1:0]    cfg,
    output logic                hide_irq,
    output logic [2*HALF_W-1:0] tmo_val,
    output logic [2*HALF_W-1:0] early_val,
    output logic                load_wr,
    output logic                clr_warn,
    output logic                clr_exp
);
    localparam int unsigned PAD = BUS_W - HALF_W;

    logic              locked;
    logic [HALF_W-1:0] tmo_lo, tmo_hi, early_lo, early_hi;
    logic              wr_any, wr_ok;

    always_comb begin
        wr_any   = bus_sel && bus_wr;
        wr_ok    = wr_any && !locked;
        load_wr  = wr_ok && (bus_addr == A_TMO_LO || bus_addr == A_TMO_HI ||
                             bus_addr == A_EARLY_LO || bus_addr == A_EARLY_HI);
        clr_warn = wr_ok && (bus_addr == A_ACK) && bus_wdata[ST_WARN];
        clr_exp  = wr_ok && (bus_addr == A_ACK) && bus_wdata[ST_EXP];
        tmo_val   = {tmo_hi, tmo_lo};
        early_val = {early_hi, early_lo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked   <= 1'b1;
            cfg      <= '0;
            hide_irq <= 1'b0;
            tmo_lo   <= '0;
            tmo_hi   <= '0;
            early_lo <= '0;
            early_hi <= '0;
        end else begin
            if (wr_any && bus_addr == A_KEY) begin
                if (bus_wdata[15:0] == UNLOCK) begin
                    locked <= 1'b0;
                end else if (bus_wdata == '0) begin
                    locked <= 1'b1;
                end
            end
            if (wr_ok) begin
                unique case (bus_addr)
                    A_TMO_LO:   tmo_lo   <= bus_wdata[HALF_W-1:0];
                    A_TMO_HI:   tmo_hi   <= bus_wdata[HALF_W-1:0];
                    A_EARLY_LO: early_lo <= bus_wdata[HALF_W-1:0];
                    A_EARLY_HI: early_hi <= bus_wdata[HALF_W-1:0];
                    A_CFG:      cfg      <= bus_wdata[CFG_W-1:0];
                    A_HIDE:     hide_irq <= bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_TMO_LO:   bus_rdata = {{PAD{1'b0}}, tmo_lo};
            A_TMO_HI:   bus_rdata = {{PAD{1'b0}}, tmo_hi};
            A_EARLY_LO: bus_rdata = {{PAD{1'b0}}, early_lo};
            A_EARLY_HI: bus_rdata = {{PAD{1'b0}}, early_hi};
            A_CFG:      bus_rdata = {{(BUS_W-CFG_W){1'b0}}, cfg};
            A_HIDE:     bus_rdata = {{(BUS_W-1){1'b0}}, hide_irq};
            A_STAT: begin
                bus_rdata[ST_WARN] = warn;
                bus_rdata[ST_EXP]  = expired;
                bus_rdata[ST_BUSY] = busy;
            end
            A_CUR_LO:   bus_rdata = {{PAD{1'b0}}, count[HALF_W-1:0]};
            A_CUR_HI:   bus_rdata = {{PAD{1'b0}}, count[2*HALF_W-1:HALF_W]};
            A_KEY:      bus_rdata = {{(BUS_W-1){1'b0}}, locked};
            default:    bus_rdata = '0;
        endcase
    end

    AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_sel && bus_wr && bus_addr == A_CFG) |=> $stable(cfg)); // R2
    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_KEY && bus_wdata[15:0] == UNLOCK) |=> !locked); // R1
    AST_LOCKED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !busy) |=> !busy || !$past(locked)); // R2
endmodule

// File: rtl/wdtk_watchdog.sv
module wdtk_watchdog
    import wdtk_pkg::*;
#(
    parameter int unsigned HALF_W       = 16,
    parameter int unsigned SETTLE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    logic [CFG_W-1:0] cfg;
    logic             hide_irq, load_wr, clr_warn, clr_exp;
    logic             busy, commit, warn, expired;
    logic [CNT_W-1:0] tmo_val, early_val, count;

    wdtk_regs #(.HALF_W(HALF_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .count(count), .warn(warn), .expired(expired),
        .cfg(cfg), .hide_irq(hide_irq), .tmo_val(tmo_val), .early_val(early_val),
        .load_wr(load_wr), .clr_warn(clr_warn), .clr_exp(clr_exp)
    );

    wdtk_loadseq #(.SETTLE_TICKS(SETTLE_TICKS)) u_load (
        .clk(clk), .rst_n(rst_n), .load_wr(load_wr), .tick(tick),
        .busy(busy), .commit(commit)
    );

    wdtk_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(cfg[CFG_RUN]),
        .commit(commit), .tmo_val(tmo_val), .early_val(early_val),
        .clr_warn(clr_warn), .clr_exp(clr_exp),
        .count(count), .warn(warn), .expired(expired)
    );

    always_comb begin
        irq_o     = warn && cfg[CFG_IRQ_EN] && !hide_irq;
        rst_req_o = expired && cfg[CFG_RST_EN];
    end

    AST_EXP_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> ($past(count) == 1 && count == 0)); // R8
    AST_WARN_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn) |-> $past(tick)); // R7
endmodule

// File: tb/sim_wdtk_watchdog.sv
module sim_wdtk_watchdog;
    import wdtk_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, rst_req_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wdtk_watchdog u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic with_tick);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = with_tick;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic count_now(output logic [31:0] c);
        logic [31:0] lo, hi;
        rd(A_CUR_LO, lo);
        rd(A_CUR_HI, hi);
        c = {hi[15:0], lo[15:0]};
    endtask

    // writes both values, then walks the settle window (R5)
    task automatic load(input logic [31:0] t, input logic [31:0] e, input logic check_busy);
        logic [31:0] s, c;
        wr(A_TMO_HI, t >> 16, 1'b0);
        wr(A_TMO_LO, t & 32'hFFFF, 1'b0);
        wr(A_EARLY_HI, e >> 16, 1'b0);
        wr(A_EARLY_LO, e & 32'hFFFF, 1'b0);
        rd(A_STAT, s);
        if (check_busy) chk("R5 busy after load", {31'b0, s[4]}, 32'd1);
        step();
        step();
        rd(A_STAT, s);
        if (check_busy) chk("R5 busy through second tick", {31'b0, s[4]}, 32'd1);
        @(negedge clk);
        rd(A_STAT, s);
        if (check_busy) chk("R5 busy drops", {31'b0, s[4]}, 32'd0);
        count_now(c);
        if (check_busy) chk("R5 count takes timeout", c, t);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(A_KEY, d);  chk("R1 reset protected", d, 32'd1);
        rd(A_CFG, d);  chk("R4 reset control", d, 32'd0);
        rd(A_STAT, d); chk("R7 reset status", d, 32'd0);
        chk("R8 reset outputs", {30'b0, irq_o, rst_req_o}, 32'd0);

        wr(A_KEY, 32'h0000E551, 1'b0);
        rd(A_KEY, d); chk("R1 unlocked", d, 32'd0);

        wr(A_CFG, 32'h4, 1'b0);
        rd(A_CFG, d); chk("R4 mode bit", d, 32'h4);
        wr(A_CFG, 32'hF, 1'b0);
        rd(A_CFG, d); chk("R4 all bits", d, 32'hF);

        // sweep of every small timeout / threshold pair (R6 R7 R8)
        for (int t = 2; t <= 6; t++) begin
            for (int e = 1; e < t; e++) begin
                wr(A_CFG, 32'h0, 1'b0);
                wr(A_ACK, 32'h9, 1'b0);
                load(t, e, (t == 2 && e == 1));
                wr(A_CFG, 32'hB, 1'b0);
                for (int k = 1; k <= t; k++) begin
                    step();
                    count_now(c);
                    chk("R6 count per tick", c, t - k);
                    rd(A_STAT, d);
                    chk("R7 warning flag", {31'b0, d[0]}, (k >= t - e) ? 32'd1 : 32'd0);
                    chk("R8 expiry flag", {31'b0, d[3]}, (k >= t) ? 32'd1 : 32'd0);
                    chk("R7 irq", {31'b0, irq_o}, (k >= t - e) ? 32'd1 : 32'd0);
                    chk("R8 reset request", {31'b0, rst_req_o}, (k >= t) ? 32'd1 : 32'd0);
                end
            end
        end

        wr(A_HIDE, 32'h1, 1'b0);
        chk("R7 masked irq", {31'b0, irq_o}, 32'd0);
        rd(A_STAT, d); chk("R7 warning kept under mask", {31'b0, d[0]}, 32'd1);
        wr(A_HIDE, 32'h0, 1'b0);
        chk("R7 unmasked irq", {31'b0, irq_o}, 32'd1);
        wr(A_CFG, 32'h3, 1'b0);
        chk("R8 reset enable off", {31'b0, rst_req_o}, 32'd0);
        step();
        count_now(c); chk("R6 holds at zero", c, 32'd0);

        wr(A_KEY, 32'h0, 1'b0);
        rd(A_KEY, d); chk("R1 relocked", d, 32'd1);
        wr(A_CFG, 32'hF, 1'b0);
        rd(A_CFG, d); chk("R2 control kept", d, 32'h3);
        wr(A_ACK, 32'h9, 1'b0);
        rd(A_STAT, d); chk("R2 flags kept", d & 32'h9, 32'h9);
        wr(A_TMO_LO, 32'h7, 1'b0);
        rd(A_STAT, d); chk("R2 no busy", {31'b0, d[4]}, 32'd0);
        rd(A_TMO_LO, d); chk("R2 load value kept", d, 32'd6);
        wr(A_KEY, 32'h0000E551, 1'b0);

        // set and clear in the same clock (R9)
        wr(A_CFG, 32'h0, 1'b0);
        wr(A_ACK, 32'h9, 1'b0);
        rd(A_STAT, d); chk("R9 clear both", d & 32'h9, 32'h0);
        load(3, 1, 1'b0);
        wr(A_CFG, 32'hB, 1'b0);
        step();
        wr(A_ACK, 32'h1, 1'b1);
        rd(A_STAT, d); chk("R9 warning set wins", {31'b0, d[0]}, 32'd1);
        wr(A_ACK, 32'h8, 1'b1);
        rd(A_STAT, d); chk("R9 expiry set wins", d & 32'h9, 32'h9);
        wr(A_ACK, 32'h1, 1'b0);
        rd(A_STAT, d); chk("R9 warning cleared alone", d & 32'h9, 32'h8);
        wr(A_ACK, 32'h8, 1'b0);
        rd(A_STAT, d); chk("R9 expiry cleared", d & 32'h9, 32'h0);
        chk("R9 outputs low", {30'b0, irq_o, rst_req_o}, 32'd0);

        // freeze and reload (R6 R10)
        wr(A_CFG, 32'h0, 1'b0);
        load(50, 10, 1'b0);
        wr(A_CFG, 32'h2, 1'b0);
        step(); step();
        count_now(c); chk("R6 running", c, 32'd48);
        wr(A_CFG, 32'h0, 1'b0);
        step(); step(); step();
        count_now(c); chk("R6 frozen", c, 32'd48);
        wr(A_CFG, 32'h2, 1'b0);
        step();
        wr(A_TMO_HI, 32'h0, 1'b0);
        wr(A_TMO_LO, 32'd20, 1'b0);
        wr(A_EARLY_HI, 32'h0, 1'b0);
        wr(A_EARLY_LO, 32'd5, 1'b0);
        step();
        count_now(c); chk("R10 old count steps while busy", c, 32'd46);
        step();
        rd(A_STAT, d); chk("R10 still busy", {31'b0, d[4]}, 32'd1);
        @(negedge clk);
        count_now(c); chk("R10 restart value", c, 32'd20);
        rd(A_STAT, d); chk("R10 busy dropped", {31'b0, d[4]}, 32'd0);

        // upper bits of the halves are dropped (R3)
        wr(A_CFG, 32'h0, 1'b0);
        wr(A_TMO_HI, 32'hABCD0001, 1'b0);
        wr(A_TMO_LO, 32'h55550002, 1'b0);
        rd(A_TMO_HI, d); chk("R3 high half readback", d, 32'h1);
        rd(A_TMO_LO, d); chk("R3 low half readback", d, 32'h2);
        step(); step();
        @(negedge clk);
        rd(A_CUR_HI, d); chk("R3 count high half", d, 32'h1);
        rd(A_CUR_LO, d); chk("R3 count low half", d, 32'h2);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule